// File: doc/BRIEF.md
# Serial Flash Status Word Responder

This block is the device-side logic of a serial flash that answers a status-read command over a mode-0 SPI link. The SPI pins are brought into the system clock domain through synchronizers, and clock edges are detected there. While chip select is low, the command byte is shifted in on the data input. If that byte is the status-read code, the block keeps driving a two-byte status word on the data output for as long as the host keeps clocking.

The status bits come from live inputs: the busy flag, the compare-mismatch flag, the protection enable, the page-size mode and seven free bits for the second byte. The block samples them again at the start of every byte, so a long read follows changes as they happen. Raising chip select ends the transfer at any bit position and releases the output.

Top module: `spi_status_responder`

## Requirements
- R1: After synchronous reset, the output-enable `spi_so_oe` is 0.
- R2: The command is sampled on rising SCK, MSB first. When the 8 bits equal 8'hD7, the first status bit is driven on the falling SCK edge that follows the 8th rising edge. There are no dummy cycles.
- R3: The first status byte is sent MSB first with this layout: bit 7 = ready (1 when `st_busy` is 0), bit 6 = `st_cmp_mismatch`, bits 5:2 = the `DENSITY_CODE` parameter (default 4'b1011), bit 1 = `st_protect_on`, bit 0 = `st_page_pow2`.
- R4: The second status byte is bit 7 = ready (same encoding as in R3) and bits 6:0 = `st_byte2_low[6:0]`.
- R5: After the second byte, output resumes with the first byte. The pair repeats for as long as chip select stays low and SCK toggles.
- R6: Each byte reflects the status inputs as they stand at that byte's first falling SCK edge. The ready bit is therefore refreshed in every byte.
- R7: Raising chip select at any bit position drops `spi_so_oe` within a few system clocks. The next selection starts with a fresh command byte.
- R8: When the command byte is anything other than 8'hD7, `spi_so_oe` stays 0 until chip select is raised.
- R9: A status read is served while `st_busy` is 1, and reports ready = 0.
- R10: `spi_so` changes only in response to a falling SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial status data to the host |
| spi_so_oe | output | 1 | Output enable for the serial data pad (0 = high impedance) |
| st_busy | input | 1 | Internal operation in progress |
| st_cmp_mismatch | input | 1 | Last page compare did not match |
| st_protect_on | input | 1 | Sector protection enabled |
| st_page_pow2 | input | 1 | Binary page size selected |
| st_byte2_low | input | 7 | Low seven bits of the second status byte |

## Verification
A falling SCK edge that starts a new byte can arrive just as the status inputs change. Two things then happen at once: the shift register reloads and the live flags are recaptured. The bench provokes this by changing busy, compare and the second-byte bits while SCK is high on the last bit of a byte, so the next falling edge must take the new values. A behavioural model predicts each byte from the inputs at that falling edge and checks every bit. A second collision, chip select rising in the middle of a byte, is judged by requiring the enable to drop and a following command to restart cleanly at the first byte.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  typedef enum logic [1:0] {
    RX_OPCODE = 2'd0,
    RX_STREAM = 2'd1,
    RX_IGNORE = 2'd2
  } rx_state_e;

  localparam logic [7:0] STATUS_READ_CODE = 8'hD7;
endpackage

// File: rtl/spi_stat_sync.sv
module spi_stat_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_stat_rx.sv
module spi_stat_rx
  import spi_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cs_n_s,
  input  logic      sck_rise,
  input  logic      si_s,
  output rx_state_e state
);
  logic [6:0] shreg;
  logic [2:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || cs_n_s) begin
      state <= RX_OPCODE;
      shreg <= '0;
      cnt   <= '0;
    end else if (state == RX_OPCODE && sck_rise) begin
      shreg <= {shreg[5:0], si_s};
      cnt   <= cnt + 3'd1;
      if (cnt == 3'd7)
        state <= ({shreg, si_s} == STATUS_READ_CODE) ? RX_STREAM : RX_IGNORE;
    end
  end

  AST_STREAM_AFTER_EIGHT: assert property (@(posedge clk) disable iff (rst)
    (state != RX_STREAM) |=> (state != RX_STREAM) || ($past(cnt) == 3'd7 && $past(sck_rise))); // R2
endmodule

// File: rtl/spi_stat_tx.sv
module spi_stat_tx #(
  parameter int B2_BITS = 7,
  parameter logic [3:0] DENSITY_CODE = 4'b1011,
  localparam int BYTE_W = B2_BITS + 1,
  localparam int POS_W = $clog2(BYTE_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n_s,
  input  logic               sck_fall,
  input  logic               stream,
  input  logic               busy,
  input  logic               cmp_mismatch,
  input  logic               protect_on,
  input  logic               page_pow2,
  input  logic [B2_BITS-1:0] byte2_low,
  output logic               so,
  output logic               oe
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] byte1, byte2;
  logic [BYTE_W-2:0] shreg;
  logic [POS_W-1:0]  pos;
  logic              byte_sel;
  logic              load;

  assign byte1 = {~busy, cmp_mismatch, DENSITY_CODE, protect_on, page_pow2};
  assign byte2 = {~busy, byte2_low};
  assign load  = stream && sck_fall && (pos == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      so <= 1'b0; oe <= 1'b0; shreg <= '0; pos <= '0; byte_sel <= 1'b0;
    end else if (cs_n_s) begin
      oe <= 1'b0; pos <= '0; byte_sel <= 1'b0;
    end else if (stream && sck_fall) begin
      oe <= 1'b1;
      if (pos == '0) {so, shreg} <= byte_sel ? byte2 : byte1;
      else           {so, shreg} <= {shreg, 1'b0};
      if (pos == LAST_POS) begin
        pos      <= '0;
        byte_sel <= ~byte_sel;
      end else begin
        pos <= pos + POS_W'(1);
      end
    end
  end

  AST_READY_LEADS_BYTE: assert property (@(posedge clk) disable iff (rst)
    load |=> (so == ~$past(busy))); // R6
  AST_OE_DROPS_ON_DESELECT: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !oe); // R7
  AST_SO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !sck_fall |=> $stable(so)); // R10
endmodule

// File: rtl/spi_status_responder.sv
module spi_status_responder
  import spi_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int B2_BITS = 7,
  parameter logic [3:0] DENSITY_CODE = 4'b1011
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               spi_sck,
  input  logic               spi_cs_n,
  input  logic               spi_si,
  output logic               spi_so,
  output logic               spi_so_oe,
  input  logic               st_busy,
  input  logic               st_cmp_mismatch,
  input  logic               st_protect_on,
  input  logic               st_page_pow2,
  input  logic [B2_BITS-1:0] st_byte2_low
);
  logic [2:0] pins_s;
  logic       cs_n_s, sck_s, si_s, sck_prev;
  logic       sck_rise, sck_fall;
  rx_state_e  rx_state;

  spi_stat_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_cs_n, spi_sck, spi_si}),
    .q(pins_s)
  );
  assign {cs_n_s, sck_s, si_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_prev & ~cs_n_s;
  assign sck_fall = ~sck_s & sck_prev & ~cs_n_s;

  spi_stat_rx u_rx (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .sck_rise(sck_rise),
    .si_s(si_s), .state(rx_state)
  );

  spi_stat_tx #(.B2_BITS(B2_BITS), .DENSITY_CODE(DENSITY_CODE)) u_tx (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .sck_fall(sck_fall),
    .stream(rx_state == RX_STREAM),
    .busy(st_busy), .cmp_mismatch(st_cmp_mismatch),
    .protect_on(st_protect_on), .page_pow2(st_page_pow2),
    .byte2_low(st_byte2_low),
    .so(spi_so), .oe(spi_so_oe)
  );

  AST_BAD_CODE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (rx_state == RX_IGNORE) |-> !spi_so_oe); // R8
endmodule

// File: tb/spi_status_responder_bench.sv
module spi_status_responder_bench;
  localparam int HALF = 8;
  localparam logic [3:0] DENS = 4'b1011;

  logic clk = 0, rst = 1;
  logic spi_sck = 0, spi_cs_n = 1, spi_si = 0;
  logic spi_so, spi_so_oe;
  logic st_busy = 0, st_cmp_mismatch = 0, st_protect_on = 0, st_page_pow2 = 0;
  logic [6:0] st_byte2_low = '0;

  int checks = 0, errors = 0;
  int m_pos = 0, m_sel = 0, m_bytes = 0;
  logic [7:0] m_byte;
  bit bad_sel = 0;
  int cs_hi = 0, since_fall = 100, cyc = 0;
  logic last_so = 0, sck_seen = 0;

  always #5 clk = ~clk;

  spi_status_responder u_spi_status_responder (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_si(spi_si),
    .spi_so(spi_so), .spi_so_oe(spi_so_oe), .st_busy(st_busy),
    .st_cmp_mismatch(st_cmp_mismatch), .st_protect_on(st_protect_on),
    .st_page_pow2(st_page_pow2), .st_byte2_low(st_byte2_low)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] model_byte(int sel);
    if (sel == 0) return {~st_busy, st_cmp_mismatch, DENS, st_protect_on, st_page_pow2};
    return {~st_busy, st_byte2_low};
  endfunction

  // Per-clock monitors: deselect release (R7), bad opcode (R8), SO timing (R10)
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      cs_hi = 0; last_so = spi_so; sck_seen = spi_sck;
    end else begin
      if (sck_seen && !spi_sck) since_fall = 0; else since_fall++;
      sck_seen = spi_sck;
      cs_hi = spi_cs_n ? cs_hi + 1 : 0;
      if (cs_hi > 5) check("R7 oe released while deselected", spi_so_oe, 0);
      if (bad_sel) check("R8 oe off after foreign opcode", spi_so_oe, 0);
      if (spi_so !== last_so) check("R10 so moved only after falling sck", since_fall <= 5, 1);
      last_so = spi_so;
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic select();
    spi_sck = 0; spi_cs_n = 0; m_pos = 0; m_sel = 0; m_bytes = 0;
    wait_clk(HALF);
  endtask

  task automatic deselect();
    spi_cs_n = 1; wait_clk(4);
    spi_sck = 0; wait_clk(HALF);
    check("R7 oe low after deselect", spi_so_oe, 0);
  endtask

  task automatic send_code(logic [7:0] code);
    for (int i = 7; i >= 0; i--) begin
      spi_sck = 0; spi_si = code[i]; wait_clk(HALF);
      spi_sck = 1; wait_clk(HALF);
    end
  endtask

  task automatic read_bits(int n, string req);
    for (int i = 0; i < n; i++) begin
      spi_sck = 0;
      if (m_pos == 0) m_byte = model_byte(m_sel);
      wait_clk(HALF);
      check({req, " oe during stream"}, spi_so_oe, 1);
      if (m_bytes >= 2) check({"R5 wrap ", req}, spi_so, m_byte[7-m_pos]);
      else              check(m_sel == 0 ? {"R3 ", req} : {"R4 ", req}, spi_so, m_byte[7-m_pos]);
      spi_sck = 1; wait_clk(HALF);
      m_pos++;
      if (m_pos == 8) begin m_pos = 0; m_sel ^= 1; m_bytes++; end
    end
  endtask

  initial begin
    wait_clk(10);
    check("R1 oe after reset", spi_so_oe, 0);
    rst = 0; wait_clk(4);
    check("R1 oe idle", spi_so_oe, 0);

    // R2 R3 R4 R5: plain read, four bytes
    st_protect_on = 1; st_byte2_low = 7'h55;
    select(); send_code(8'hD7);
    read_bits(32, "R2 basic");
    deselect();

    // R6 R9: busy read with per-byte refresh
    st_busy = 1; st_cmp_mismatch = 1; st_protect_on = 0; st_page_pow2 = 1; st_byte2_low = 7'h2A;
    select(); send_code(8'hD7);
    read_bits(8, "R9 busy");
    st_busy = 0; st_byte2_low = 7'h11;
    read_bits(8, "R6 refresh b2");
    st_busy = 1; st_cmp_mismatch = 0;
    read_bits(8, "R6 refresh b1");
    st_busy = 0; st_page_pow2 = 0;
    read_bits(8, "R6 refresh b2 again");
    deselect();

    // R7: cut mid-byte, then restart cleanly
    select(); send_code(8'hD7);
    read_bits(3, "R7 partial");
    deselect();
    select(); send_code(8'hD7);
    read_bits(16, "R7 restart");
    deselect();

    // R8: foreign codes
    select(); send_code(8'hD6);
    bad_sel = 1;
    for (int i = 0; i < 16; i++) begin
      spi_sck = 0; wait_clk(HALF); spi_sck = 1; wait_clk(HALF);
    end
    bad_sel = 0;
    deselect();
    select(); send_code(8'h57);
    bad_sel = 1;
    for (int i = 0; i < 8; i++) begin
      spi_sck = 0; wait_clk(HALF); spi_sck = 1; wait_clk(HALF);
    end
    bad_sel = 0;
    deselect();
    st_busy = 1;
    select(); send_code(8'hD7);
    read_bits(10, "R8 valid after foreign");
    deselect();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule